// File: doc/BRIEF.md
# Bit Field Deposit Unit

This execution unit handles the deposit group of a 32-bit processor's integer instructions. It takes a right-justified value, either a register operand or a small signed immediate from the instruction, and writes its low bits into a window of the destination word. The window's start comes from an immediate field of the instruction or from the shift-amount register (SAR). The bits outside the window either keep the destination's old contents or are cleared.

The issue stage presents the instruction word, the two register values and SAR with a valid strobe. One clock later the unit drives the target register index, the new 32-bit value, a write enable and a flag that tells the pipeline to nullify the following instruction. Words whose major opcode is not the deposit group give no write.

Top module: `bitdep_unit`

## Requirements
- R1: While reset is asserted, and after it until the first accepted instruction, `wen_o`, `nullify_o`, `tidx_o` and `result_o` are all zero.
- R2: A cycle with `valid_i` low, or with `insn_i[31:26]` other than 6'b110101, makes `wen_o` and `nullify_o` zero one cycle later.
- R3: A valid instruction with `insn_i[31:26]` equal to 6'b110101 makes `wen_o` one and `tidx_o` equal to `insn_i[25:21]` exactly one cycle later, with `result_o` and `nullify_o` belonging to that same instruction.
- R4: The field length is 32 minus `insn_i[4:0]`, so a zero there means a full 32-bit field. When start position plus length is above 32, the length is cut to 32 minus the start position.
- R5: With `insn_i[10]` set, bits outside the field keep the value of `tval_i`. With it clear, they are zero.
- R6: When `insn_i[11]` is 1, the field starts at bit `insn_i[9:5]` (little-endian numbering), and the low bits of the value fill the field upward from there.
- R7: When `insn_i[11]` is 0, the field's lowest bit lands at little-endian position 31 minus `sar_i`. Value bits that would land above bit 31 are dropped.
- R8: When `insn_i[12]` is 1, the value is a 5-bit signed immediate, sign-extended. Its sign is `insn_i[16]` and its lower four bits are `insn_i[20:17]`, so it equals {bit 16, bits 20:17}. When `insn_i[12]` is 0, the value is `rval_i`.
- R9: The condition in `insn_i[15:13]` sets `nullify_o`. Code 1 asserts it when the result is zero. Code 2 asserts it when result bit 31 is one. Every other code leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| rval_i | input | 32 | Value of the source register |
| tval_i | input | 32 | Current value of the target register |
| sar_i | input | 5 | Shift-amount register |
| tidx_o | output | 5 | Target register index |
| result_o | output | 32 | Value to write to the target |
| wen_o | output | 1 | Write enable for the target |
| nullify_o | output | 1 | Nullify the next instruction |

## Verification
The assertions assume that one instruction word sits on the inputs for a single cycle and that its fields are the only description of the operation. They also assume that `sar_i` and the register values are stable across the capturing edge. The bench changes inputs only on the falling edge, so every word is sampled whole. Its random words keep the deposit opcode most of the time and sweep every condition code, form bit, length and position. Now and then it mixes in a foreign opcode or a cycle with valid low, so the idle properties are exercised as well.

// File: rtl/bitdep_unit.sv
module bitdep_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  input  logic [31:0] rval_i,
  input  logic [31:0] tval_i,
  input  logic [4:0]  sar_i,
  output logic [4:0]  tidx_o,
  output logic [31:0] result_o,
  output logic        wen_o,
  output logic        nullify_o
);
  localparam logic [5:0] OPC = 6'b110101;

  logic        hit;
  logic [4:0]  pos;
  logic [5:0]  len_raw, room, len;
  logic [31:0] src, lowmask, fmask, field, bg, res;
  logic        cond_true;

  assign hit     = valid_i && (insn_i[31:26] == OPC);
  assign pos     = insn_i[11] ? insn_i[9:5] : ~sar_i;
  assign len_raw = 6'd32 - {1'b0, insn_i[4:0]};
  assign room    = 6'd32 - {1'b0, pos};
  assign len     = (len_raw > room) ? room : len_raw;
  assign src     = insn_i[12] ? {{28{insn_i[16]}}, insn_i[20:17]} : rval_i;
  assign lowmask = len[5] ? 32'hFFFF_FFFF : ((32'd1 << len[4:0]) - 32'd1);
  assign fmask   = lowmask << pos;
  assign field   = (src << pos) & fmask;
  assign bg      = insn_i[10] ? tval_i : 32'd0;
  assign res     = (bg & ~fmask) | field;

  always_comb begin
    case (insn_i[15:13])
      3'd1:    cond_true = (res == 32'd0);
      3'd2:    cond_true = res[31];
      default: cond_true = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wen_o     <= 1'b0;
      nullify_o <= 1'b0;
      tidx_o    <= 5'd0;
      result_o  <= 32'd0;
    end else begin
      wen_o     <= hit;
      nullify_o <= hit && cond_true;
      if (hit) begin
        tidx_o   <= insn_i[25:21];
        result_o <= res;
      end
    end
  end
endmodule

// File: rtl/bitdep_unit_chk.sv
module bitdep_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic [31:0] insn_i,
  input logic [4:0]  tidx_o,
  input logic [31:0] result_o,
  input logic        wen_o,
  input logic        nullify_o
);
  logic hit_c;
  assign hit_c = valid_i && (insn_i[31:26] == 6'b110101);

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_c |=> (!wen_o && !nullify_o));

  a_r3_target: assert property (@(posedge clk) disable iff (!rst_n)
    hit_c |=> (wen_o && tidx_o == $past(insn_i[25:21])));

  a_r9_eqzero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_c && insn_i[15:13] == 3'd1) |=> (nullify_o == (result_o == 32'd0)));

  a_r9_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_c && insn_i[15:13] == 3'd2) |=> (nullify_o == result_o[31]));

  a_r9_never: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_c && insn_i[15:13] != 3'd1 && insn_i[15:13] != 3'd2) |=> !nullify_o);

  a_r5_zero_below: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_c && !insn_i[10] && insn_i[11]) |=>
      ((result_o & ((32'd1 << $past(insn_i[9:5])) - 32'd1)) == 32'd0));

  a_r1_nowrite: assert property (@(posedge clk)
    !rst_n |=> (!wen_o && !nullify_o));
endmodule

bind bitdep_unit bitdep_unit_chk u_chk (.*);

// File: tb/sim_bitdep_unit.sv
module sim_bitdep_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [31:0] rval_i = '0;
  logic [31:0] tval_i = '0;
  logic [4:0]  sar_i = '0;
  logic [4:0]  tidx_o;
  logic [31:0] result_o;
  logic        wen_o;
  logic        nullify_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitdep_unit u0 (.*);

  function automatic logic [31:0] mk(input logic [1:0] op2, input logic [4:0] t,
      input logic [4:0] r, input logic [2:0] c, input logic nz,
      input logic [4:0] cpos, input logic [4:0] clen);
    return {6'b110101, t, r, c, op2, nz, cpos, clen};
  endfunction

  function automatic logic [31:0] ref_res(input logic [31:0] w, input logic [31:0] rv,
      input logic [31:0] tv, input logic [4:0] sar);
    int p, n;
    logic [31:0] v, o;
    n = 32 - int'(w[4:0]);
    p = w[11] ? int'(w[9:5]) : 31 - int'(sar);
    if (p + n > 32) n = 32 - p;
    if (w[12]) v = {{28{w[16]}}, w[20:17]};
    else       v = rv;
    o = w[10] ? tv : 32'd0;
    for (int i = 0; i < 32; i++)
      if (i >= p && i < p + n) o[i] = v[i - p];
    return o;
  endfunction

  function automatic logic ref_nul(input logic [31:0] w, input logic [31:0] r);
    if (w[15:13] == 3'd1) return r == 32'd0;
    if (w[15:13] == 3'd2) return r[31];
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic v, input logic [31:0] w,
      input logic [31:0] rv, input logic [31:0] tv, input logic [4:0] sar);
    logic hit;
    logic [31:0] e;
    @(negedge clk);
    valid_i = v; insn_i = w; rval_i = rv; tval_i = tv; sar_i = sar;
    @(negedge clk);
    valid_i = 1'b0;
    hit = v && (w[31:26] == 6'b110101);
    e = ref_res(w, rv, tv, sar);
    chk({tag, " wen"}, {31'd0, wen_o}, {31'd0, hit});
    if (hit) begin
      chk({tag, " tidx"}, {27'd0, tidx_o}, {27'd0, w[25:21]});
      chk({tag, " result"}, result_o, e);
      chk({tag, " nullify"}, {31'd0, nullify_o}, {31'd0, ref_nul(w, e)});
    end else begin
      chk({tag, " nullify"}, {31'd0, nullify_o}, 32'd0);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wen", {31'd0, wen_o}, 32'd0);
    chk("R1 nullify", {31'd0, nullify_o}, 32'd0);
    chk("R1 result", result_o, 32'd0);
    chk("R1 tidx", {27'd0, tidx_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", {31'd0, wen_o}, 32'd0);

    // R2 invalid and foreign opcode
    run("R2 novalid", 1'b0, mk(2'b01, 5'd3, 5'd4, 3'd1, 1'b0, 5'd0, 5'd0), 32'h0, 32'h0, 5'd0);
    run("R2 opcode", 1'b1, {6'b110100, 26'h0002000}, 32'h0, 32'h0, 5'd0);
    // R3, R6 merge at cpos 8 length 8
    run("R3 R6 merge", 1'b1, mk(2'b01, 5'd17, 5'd2, 3'd0, 1'b1, 5'd8, 5'd24),
        32'h0000_00AB, 32'h1234_5678, 5'd0);
    // R5 zero background
    run("R5 zero", 1'b1, mk(2'b01, 5'd9, 5'd2, 3'd0, 1'b0, 5'd4, 5'd28),
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    // R4 full length and clamp
    run("R4 full", 1'b1, mk(2'b01, 5'd1, 5'd2, 3'd0, 1'b1, 5'd0, 5'd0),
        32'hCAFE_F00D, 32'h1111_1111, 5'd0);
    run("R4 clamp", 1'b1, mk(2'b01, 5'd1, 5'd2, 3'd0, 1'b1, 5'd28, 5'd24),
        32'h0000_00FF, 32'h0000_0000, 5'd0);
    // R7 SAR positions
    run("R7 sar0", 1'b1, mk(2'b00, 5'd5, 5'd2, 3'd0, 1'b0, 5'd0, 5'd24),
        32'h0000_00FF, 32'h0, 5'd0);
    run("R7 sar31", 1'b1, mk(2'b00, 5'd5, 5'd2, 3'd0, 1'b1, 5'd0, 5'd28),
        32'h0000_0005, 32'hFFFF_FFFF, 5'd31);
    // R8 immediate values: -1 and -16
    w = mk(2'b11, 5'd6, 5'b11111, 3'd0, 1'b0, 5'd4, 5'd24);
    run("R8 minus1", 1'b1, w, 32'h0, 32'h0, 5'd0);
    w = mk(2'b10, 5'd6, 5'b00001, 3'd0, 1'b0, 5'd0, 5'd0);
    run("R8 minus16 sar", 1'b1, w, 32'h0, 32'h0, 5'd0);
    w = mk(2'b11, 5'd6, 5'b01110, 3'd0, 1'b0, 5'd0, 5'd0);
    run("R8 plus7", 1'b1, w, 32'hFFFF_FFFF, 32'h0, 5'd0);
    // R9 conditions
    run("R9 eqzero", 1'b1, mk(2'b01, 5'd2, 5'd2, 3'd1, 1'b0, 5'd0, 5'd0),
        32'h0, 32'hFFFF_FFFF, 5'd0);
    run("R9 negative", 1'b1, mk(2'b01, 5'd2, 5'd2, 3'd2, 1'b0, 5'd31, 5'd31),
        32'h1, 32'h0, 5'd0);
    run("R9 never", 1'b1, mk(2'b01, 5'd2, 5'd2, 3'd5, 1'b0, 5'd0, 5'd0),
        32'h0, 32'h0, 5'd0);

    // random mix of forms, lengths, positions and conditions
    for (int k = 0; k < 400; k++) begin
      logic v;
      w = $urandom;
      if (($urandom % 8) != 0) w[31:26] = 6'b110101;
      v = (($urandom % 10) != 0);
      run("R4 R6 R7 R8 R9 random", v, w, $urandom, $urandom, 5'($urandom));
    end

    done = 1'b1;
    finish_run();
  end
endmodule